// File: doc/BRIEF.md
# Eight-Bit Arithmetic/Logic Unit with Status Flags

This block is the data path of a small accumulator machine. A combinational unit takes an accumulator byte, a second operand byte, a carry input and a four-bit operation code. It returns an 8-bit result in the same cycle. The unit can add, add with carry, subtract, subtract with borrow, AND, OR, XOR, complement the accumulator, and rotate in four ways.

Alongside the result it works out five status conditions: sign, zero, half-carry, even parity and carry/borrow. These are captured at the rising clock edge into a five-bit flag register. Each operation has its own set of flags it may change. A per-flag write mask lets the surrounding sequencer narrow that set further, one instruction at a time. The carry input is normally fed back from the registered carry flag by the sequencer.

Top module: `alu8_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the flag register is cleared to 5'b00000 on that edge.
- R2: Op 0 (add) gives `result` = (A + B) mod 256 and op 1 (add with carry) gives (A + B + `carry_in`) mod 256. The carry flag loads the carry out of bit 7.
- R3: Op 2 (subtract) gives (A − B) mod 256 and op 3 (subtract with borrow) gives (A − B − `carry_in`) mod 256. The carry flag loads 1 exactly when the true difference is negative.
- R4: On the four arithmetic ops, the half-carry flag loads the carry from bit 3 into bit 4 for additions. For subtractions it loads the borrow into bit 3, which is 1 when A[3:0] < B[3:0] + borrow-in.
- R5: On arithmetic and logical ops (codes 0 to 6), the sign flag loads result bit 7. The zero flag loads 1 exactly when the result is 0. The parity flag loads 1 exactly when the result has an even number of ones.
- R6: Op 4 (AND), op 5 (OR) and op 6 (XOR) give the bitwise result of A and B, and load 0 into both the carry and half-carry flags.
- R7: Op 7 gives `result` = ~A and leaves every flag unchanged.
- R8: Op 8 rotates A left (bit 7 into bit 0), op 9 rotates right (bit 0 into bit 7), op 10 rotates left through `carry_in`, and op 11 rotates right through `carry_in`. Each loads the bit shifted out into the carry flag and leaves the other four flags unchanged.
- R9: The flag vector is {sign, zero, half-carry, parity, carry} at bits 4 down to 0. A flag loads at an edge only if its bit in `flag_we` is 1 and the op may change it; otherwise it keeps its value.
- R10: Op codes 12 to 15 pass A to `result` unchanged and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag register loads on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand A |
| opb_in | input | 8 | Second operand B |
| carry_in | input | 1 | Carry/borrow input for op 1, op 3, op 10 and op 11 |
| flag_we | input | 5 | Per-flag write mask, same bit order as `flags_q` |
| result | output | 8 | Combinational result |
| flags_q | output | 5 | Registered flags {S, Z, AC, P, CY} |

## Verification
Several flag conditions fall in the same cycle as the result. A single subtraction can produce a zero result, a borrow, a half-borrow and even parity all at once, and the write mask then decides which of them land. Operand pairs are driven to provoke these coincidences: equal operands with a borrow-in, 0x00 minus 0x01, and 0xFF plus 0x01. Random ops, operands and masks are mixed in with them. After every clock edge, the result and all five flags are compared with a behavioural model that keeps its own flag state.

// File: rtl/alu8_pkg.sv
// Package: op codes and flag bit positions shared by the ALU modules.
// Assumes a 4-bit op code; the flag order is part of the port contract.
package alu8_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
        OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_CPL = 4'd7,
        OP_ROL = 4'd8, OP_ROR = 4'd9, OP_RLT = 4'd10, OP_RRT = 4'd11,
        OP_NOP12 = 4'd12, OP_NOP13 = 4'd13, OP_NOP14 = 4'd14, OP_NOP15 = 4'd15
    } alu_op_e;

    localparam int NFLAGS = 5;
    localparam int F_CY = 0;
    localparam int F_P  = 1;
    localparam int F_AC = 2;
    localparam int F_Z  = 3;
    localparam int F_S  = 4;
endpackage

// File: rtl/alu8_arith.sv
// Adder/subtractor with split nibble carry chain.
// Subtraction is A + ~B + ~borrow_in; the carry outputs are inverted back to
// borrows, so both outputs read "1 = carry" for add and "1 = borrow" for sub.
module alu8_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             use_cin,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             half
);
    localparam int LOW = 4;
    localparam int HIW = WIDTH - LOW;

    logic [WIDTH-1:0] b_eff;
    logic             c0;
    logic [LOW:0]     lo_sum;
    logic [HIW:0]     hi_sum;

    // Operand conditioning for add or subtract.
    always_comb begin
        b_eff = sub ? ~b : b;
        c0    = sub ? ~(use_cin & cin) : (use_cin & cin);
    end

    // Two-stage carry chain: low nibble, then upper part.
    always_comb begin
        lo_sum = {1'b0, a[LOW-1:0]} + {1'b0, b_eff[LOW-1:0]} + {{LOW{1'b0}}, c0};
        hi_sum = {1'b0, a[WIDTH-1:LOW]} + {1'b0, b_eff[WIDTH-1:LOW]}
                 + {{HIW{1'b0}}, lo_sum[LOW]};
        sum    = {hi_sum[HIW-1:0], lo_sum[LOW-1:0]};
        half   = sub ? ~lo_sum[LOW] : lo_sum[LOW];
        cout   = sub ? ~hi_sum[HIW] : hi_sum[HIW];
    end
endmodule

// File: rtl/alu8_logic.sv
// Bitwise operations, complement and the four rotates.
// Assumes op is decoded by the caller; shout is the bit leaving a rotate.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             shout
);
    // Select the logic or rotate result for the current op.
    always_comb begin
        res   = a;
        shout = 1'b0;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_CPL: res = ~a;
            OP_ROL: begin res = {a[WIDTH-2:0], a[WIDTH-1]}; shout = a[WIDTH-1]; end
            OP_ROR: begin res = {a[0], a[WIDTH-1:1]};       shout = a[0];       end
            OP_RLT: begin res = {a[WIDTH-2:0], cin};        shout = a[WIDTH-1]; end
            OP_RRT: begin res = {cin, a[WIDTH-1:1]};        shout = a[0];       end
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_flag_reg.sv
// Five-bit flag register with a load enable per bit.
// Assumes synchronous active-low reset; unloaded bits hold.
module alu8_flag_reg #(
    parameter int NBITS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] load,
    input  logic [NBITS-1:0] d,
    output logic [NBITS-1:0] q
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        // Per-flag storage with its own enable.
        always_ff @(posedge clk) begin
            if (!rst_n)       q[i] <= 1'b0;
            else if (load[i]) q[i] <= d[i];
        end
    end
endmodule

// File: rtl/alu8_top.sv
// 8-bit ALU top: decodes the op, selects the result, forms candidate flags
// and the per-op update set, and stores the masked flags in a register.
// Assumes carry_in is supplied by the sequencer (normally the CY flag).
module alu8_top
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0] opb_in,
    input  logic             carry_in,
    input  logic [NFLAGS-1:0] flag_we,
    output logic [WIDTH-1:0] result,
    output logic [NFLAGS-1:0] flags_q
);
    alu_op_e          opc;
    logic             is_arith, is_logic, is_rot, is_sub, use_cin;
    logic [WIDTH-1:0] ar_sum, lg_res;
    logic             ar_cout, ar_half, lg_shout;
    logic [NFLAGS-1:0] cand, affect, load;

    assign opc = alu_op_e'(op);

    // Op group decode.
    always_comb begin
        is_arith = (opc == OP_ADD) || (opc == OP_ADC) || (opc == OP_SUB) || (opc == OP_SBB);
        is_logic = (opc == OP_AND) || (opc == OP_OR)  || (opc == OP_XOR);
        is_rot   = (opc == OP_ROL) || (opc == OP_ROR) || (opc == OP_RLT) || (opc == OP_RRT);
        is_sub   = (opc == OP_SUB) || (opc == OP_SBB);
        use_cin  = (opc == OP_ADC) || (opc == OP_SBB);
    end

    alu8_arith #(.WIDTH(WIDTH)) u_arith (
        .a(acc_in), .b(opb_in), .cin(carry_in), .use_cin(use_cin), .sub(is_sub),
        .sum(ar_sum), .cout(ar_cout), .half(ar_half)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .op(opc), .a(acc_in), .b(opb_in), .cin(carry_in),
        .res(lg_res), .shout(lg_shout)
    );

    // Result mux between the adder and the logic/rotate unit.
    assign result = is_arith ? ar_sum : lg_res;

    // Candidate flag values and the set of flags each op group may change.
    always_comb begin
        cand        = '0;
        cand[F_S]   = result[WIDTH-1];
        cand[F_Z]   = (result == '0);
        cand[F_P]   = ~^result;
        cand[F_AC]  = is_arith & ar_half;
        cand[F_CY]  = is_arith ? ar_cout : (is_rot & lg_shout);
        if (is_arith || is_logic) affect = '1;
        else if (is_rot)          affect = NFLAGS'(1) << F_CY;
        else                      affect = '0;
        load = affect & flag_we;
    end

    alu8_flag_reg #(.NBITS(NFLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .load(load), .d(cand), .q(flags_q)
    );
endmodule

// File: rtl/alu8_checker.sv
// Property checker for alu8_top, bound to every instance of it.
module alu8_checker
    import alu8_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op,
    input logic [7:0]  result,
    input logic [4:0]  flag_we,
    input logic [4:0]  flags_q
);
    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> flags_q == 5'b0);

    a_r7_cpl_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_CPL |=> $stable(flags_q));

    a_r6_logic_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op inside {OP_AND, OP_OR, OP_XOR}) && flag_we[F_CY] |=> flags_q[F_CY] == 1'b0);

    a_r8_rotate_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
        (op inside {OP_ROL, OP_ROR, OP_RLT, OP_RRT}) |=> $stable(flags_q[4:1]));

    a_r9_mask_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we == 5'b0 |=> $stable(flags_q));

    a_r5_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_ADD && flag_we[F_Z] |=> flags_q[F_Z] == ($past(result) == 8'd0));

    a_r5_parity_even: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_XOR && flag_we[F_P] |=> flags_q[F_P] == ~^$past(result));

    a_r10_unused_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        op >= 4'd12 |=> $stable(flags_q));
endmodule

bind alu8_top alu8_checker u_chk (
    .clk(clk), .rst_n(rst_n), .op(op), .result(result),
    .flag_we(flag_we), .flags_q(flags_q)
);

// File: tb/tb_alu8_top.sv
module tb_alu8_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] acc_in = 8'd0, opb_in = 8'd0;
    logic       carry_in = 1'b0;
    logic [4:0] flag_we = 5'd0;
    logic [7:0] result;
    logic [4:0] flags_q;

    int checks = 0;
    int failures = 0;
    logic [4:0] mflags = 5'd0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_top dut (
        .clk(clk), .rst_n(rst_n), .op(op), .acc_in(acc_in), .opb_in(opb_in),
        .carry_in(carry_in), .flag_we(flag_we), .result(result), .flags_q(flags_q)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h op=%0d a=%0h b=%0h c=%0b", req, act, exp,
                     op, acc_in, opb_in, carry_in);
        end
    endtask

    // Behavioural model: result, new candidate flags, set of affected flags.
    task automatic model(input int o, input int a, input int b, input int c,
                         output int r, output logic [4:0] nf, output logic [4:0] aff);
        int full, lo;
        nf = 5'd0; aff = 5'd0; r = a;
        case (o)
            0, 1: begin
                full = a + b + ((o == 1) ? c : 0);
                lo   = (a % 16) + (b % 16) + ((o == 1) ? c : 0);
                r = full % 256; nf[0] = full > 255; nf[2] = lo > 15; aff = 5'b11111;
            end
            2, 3: begin
                full = a - b - ((o == 3) ? c : 0);
                lo   = (a % 16) - (b % 16) - ((o == 3) ? c : 0);
                r = (full + 512) % 256; nf[0] = full < 0; nf[2] = lo < 0; aff = 5'b11111;
            end
            4: begin r = a & b; aff = 5'b11111; end
            5: begin r = a | b; aff = 5'b11111; end
            6: begin r = a ^ b; aff = 5'b11111; end
            7: r = 255 - a;
            8:  begin r = (a * 2) % 256 + a / 128; nf[0] = a >= 128; aff = 5'b00001; end
            9:  begin r = a / 2 + (a % 2) * 128;   nf[0] = a % 2;    aff = 5'b00001; end
            10: begin r = (a * 2) % 256 + c;       nf[0] = a >= 128; aff = 5'b00001; end
            11: begin r = a / 2 + c * 128;         nf[0] = a % 2;    aff = 5'b00001; end
            default: r = a;
        endcase
        if (o <= 6) begin
            int ones = 0;
            for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
            nf[4] = r >= 128; nf[3] = (r == 0); nf[1] = (ones % 2 == 0);
        end
    endtask

    function automatic string tag_of(input int o);
        case (o)
            0, 1: return "R2";
            2, 3: return "R3";
            4, 5, 6: return "R6";
            7: return "R7";
            8, 9, 10, 11: return "R8";
            default: return "R10";
        endcase
    endfunction

    // One cycle: drive at negedge, check result, then check flags after the edge.
    task automatic step(input int o, input int a, input int b, input int c,
                        input logic [4:0] we, input string ftag);
        int r; logic [4:0] nf, aff;
        @(negedge clk);
        op = 4'(o); acc_in = 8'(a); opb_in = 8'(b); carry_in = 1'(c); flag_we = we;
        #1;
        model(o, a, b, c, r, nf, aff);
        check(tag_of(o), int'(result), r);
        for (int i = 0; i < 5; i++) if (aff[i] && we[i]) mflags[i] = nf[i];
        @(posedge clk); #1;
        check(ftag, int'(flags_q), int'(mflags));
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1 check("R1", int'(flags_q), 0);
        @(negedge clk); rst_n = 1'b1;
        // R2: carry out and zero from 0xFF+0x01; half carry from 0x0F+0x01
        step(0, 8'hFF, 8'h01, 0, 5'h1F, "R2");
        step(1, 8'h0F, 8'h00, 1, 5'h1F, "R4");
        step(1, 8'h7F, 8'h80, 1, 5'h1F, "R5");
        // R3: borrow cases
        step(2, 8'h00, 8'h01, 0, 5'h1F, "R3");
        step(3, 8'h55, 8'h55, 1, 5'h1F, "R3");
        step(3, 8'h55, 8'h54, 1, 5'h1F, "R5");
        step(2, 8'h10, 8'h01, 0, 5'h1F, "R4");
        // R6: logic clears carry
        step(2, 8'h00, 8'h01, 0, 5'h1F, "R3");
        step(4, 8'hF0, 8'h0F, 0, 5'h1F, "R6");
        step(2, 8'h00, 8'h01, 0, 5'h1F, "R3");
        step(6, 8'hA5, 8'h5A, 0, 5'h1F, "R6");
        step(5, 8'h01, 8'h02, 0, 5'h1F, "R5");
        // R7: complement leaves flags
        step(7, 8'h3C, 8'h00, 0, 5'h1F, "R7");
        // R8: rotates
        step(8, 8'h81, 8'h00, 0, 5'h1F, "R8");
        step(9, 8'h81, 8'h00, 0, 5'h1F, "R8");
        step(10, 8'h40, 8'h00, 1, 5'h1F, "R8");
        step(11, 8'h02, 8'h00, 1, 5'h1F, "R8");
        // R9: mask limits which flags load
        step(0, 8'hFF, 8'h01, 0, 5'b01000, "R9");
        step(2, 8'h00, 8'h01, 0, 5'b00000, "R9");
        step(2, 8'h00, 8'h01, 0, 5'b10001, "R9");
        // R10: unused codes
        for (int k = 12; k < 16; k++) step(k, 8'h9A, 8'h11, 1, 5'h1F, "R10");
        // Random mix
        for (int n = 0; n < 600; n++)
            step($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
                 $urandom_range(0, 1), 5'($urandom_range(0, 31)), "R9");
        // R1 again: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 check("R1", int'(flags_q), 0);
        mflags = 5'd0;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule